// File: doc/BRIEF.md
# Broadcast-Driven 8-bit Processing Element

This block is one processing element of a lock-step array. A central controller presents one decoded instruction per clock to every element at once, and each element applies it to its own state. The state is five byte registers (A8, B8, C8, IO8 and the memory pointer PTR) and five flags (A1, B1, C1, IO1 and the run flag RUN). A local store of byte cells and single-bit cells is addressed through PTR. The arithmetic unit provides add and subtract with carry, magnitude compare, a 9-bit ring rotate through B8 and B1, and a logic operation that takes a 4-bit truth table.

An element whose RUN flag is clear ignores every instruction except the wake-up instruction. A streamed match mode lets the controller push a byte string past all elements. Each element compares the string against its store at PTR, one byte per clock, and drops out of the run set on the first mismatch. The controller reads values back through a report byte and a report bit. It also sees the RUN flag directly.

Top module: `simd_pe`

## Requirements
- R1: After reset, every byte register, A1, B1, C1, IO1 and both report outputs are 0, and RUN is 1. Register select codes are A8/A1=0, B8/B1=1, C8/C1=2, IO8/IO1=3, PTR/RUN=4, and store cell at PTR=5. Codes 6 and 7 read as 0 and ignore writes. PTR reads as a byte with zero upper bits.
- R2: ADD (opcode 8) writes C8 = low 8 bits of (operand + A8 + C1) and writes the carry out to C1.
- R3: SUB (opcode 9) writes C8 = low 8 bits of (A8 - operand - C1) and writes 1 to C1 when the result was negative, else 0.
- R4: CMP (opcode 10) sets A1 = (operand == A8) and B1 = (operand > A8), both unsigned.
- R5: ROTR (opcode 11) moves {B1,B8} one place right as a 9-bit ring: B8[0] goes to B1 and the old B1 goes to B8[7]. ROTL (opcode 12) is the mirror image: B8[7] goes to B1 and the old B1 goes to B8[0].
- R6: LOG8 (opcode 13) writes C8[i] = fn[{A8[i],B8[i]}] for each bit. LOG1 (opcode 14) writes C1 = fn[{A1,B1}]. Under this encoding, AND is 4'b1000, OR is 4'b1110 and XOR is 4'b0110.
- R7: While RUN is 0, every instruction leaves all state and both report outputs unchanged, except ENABLE (opcode 17), which sets RUN to 1. ENABLE also sets RUN to 1 when RUN is already 1.
- R8: RD8 (3) and RD1 (5) load the byte or bit cell at PTR into the destination. WR8 (4) and WR1 (6) store the source at PTR. INC (7) adds 1 to PTR modulo 64. A byte written to PTR keeps its low 6 bits.
- R9: While the string strobe is high, each valid cycle compares the broadcast byte with the byte cell at PTR and then advances PTR, and the opcode is ignored. A mismatch clears RUN. An element with RUN clear ignores the rest of the string and keeps its PTR.
- R10: BC8 (15) loads the broadcast byte into the destination byte register. BC1 (16) loads broadcast bit 0 into the destination flag.
- R11: MOV8 (1) and MOV1 (2) copy source to destination. REP8 (18) and REP1 (19) copy the source to the report byte or bit. NOP (0) and codes 20 to 31 change nothing. Every instruction takes effect at the clock edge on which it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction or string byte is presented this cycle |
| opcode | input | 5 | Decoded instruction code |
| src_sel | input | 3 | Source register select |
| dst_sel | input | 3 | Destination register select |
| logic_fn | input | 4 | Truth table for the logic operations |
| bcast_data | input | 8 | Broadcast byte from the controller |
| str_mode | input | 1 | String match strobe |
| rpt_byte | output | 8 | Last reported byte |
| rpt_bit | output | 1 | Last reported bit |
| enabled | output | 1 | Current RUN flag |

## Verification
The hardest state to reach from the ports is an element that fails partway through a string and must then stay idle. Its PTR has to freeze on the byte after the mismatch, while later string bytes that would have matched must not bring RUN back. To reach it, the stimulus first fills the store through ordinary write and increment instructions and then rewinds PTR by a broadcast. It then streams a string whose second byte is wrong and whose remaining bytes match the store. The frozen pointer is brought out afterwards with ENABLE followed by a report of PTR. A long stream of mixed instructions, including self-disable through a RUN write, then runs against the reference model.

// File: rtl/pe_pkg.sv
package pe_pkg;

    typedef enum logic [4:0] {
        OP_NOP    = 5'd0,
        OP_MOV8   = 5'd1,
        OP_MOV1   = 5'd2,
        OP_RD8    = 5'd3,
        OP_WR8    = 5'd4,
        OP_RD1    = 5'd5,
        OP_WR1    = 5'd6,
        OP_INC    = 5'd7,
        OP_ADD    = 5'd8,
        OP_SUB    = 5'd9,
        OP_CMP    = 5'd10,
        OP_ROTR   = 5'd11,
        OP_ROTL   = 5'd12,
        OP_LOG8   = 5'd13,
        OP_LOG1   = 5'd14,
        OP_BC8    = 5'd15,
        OP_BC1    = 5'd16,
        OP_ENABLE = 5'd17,
        OP_REP8   = 5'd18,
        OP_REP1   = 5'd19
    } pe_op_e;

    localparam logic [2:0] SEL_A   = 3'd0;
    localparam logic [2:0] SEL_B   = 3'd1;
    localparam logic [2:0] SEL_C   = 3'd2;
    localparam logic [2:0] SEL_IO  = 3'd3;
    localparam logic [2:0] SEL_PTR = 3'd4;
    localparam logic [2:0] SEL_MEM = 3'd5;

endpackage

// File: rtl/pe_lut.sv
module pe_lut (
    input  logic [3:0] fn,
    input  logic       a,
    input  logic       b,
    output logic       y
);
    // The truth table is indexed by the operand pair {a,b}.
    always_comb begin
        y = fn[{a, b}];
    end
endmodule

// File: rtl/pe_alu.sv
module pe_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a8,
    input  logic [DW-1:0] b8,
    input  logic [DW-1:0] opnd,
    input  logic          a1,
    input  logic          b1,
    input  logic          c1,
    input  logic [3:0]    fn,
    output logic [DW-1:0] sum,
    output logic          carry,
    output logic [DW-1:0] diff,
    output logic          borrow,
    output logic          eq,
    output logic          gt,
    output logic [DW-1:0] log8,
    output logic          log1,
    output logic [DW-1:0] rotr_b8,
    output logic          rotr_b1,
    output logic [DW-1:0] rotl_b8,
    output logic          rotl_b1
);
    localparam int XW = DW + 1;

    logic [XW-1:0] add_x;
    logic [XW-1:0] sub_x;

    always_comb begin
        add_x  = {1'b0, a8} + {1'b0, opnd} + {{DW{1'b0}}, c1};
        sub_x  = {1'b0, a8} - {1'b0, opnd} - {{DW{1'b0}}, c1};
        sum    = add_x[DW-1:0];
        carry  = add_x[DW];
        diff   = sub_x[DW-1:0];
        borrow = sub_x[DW];
        eq     = (opnd == a8);
        gt     = (opnd > a8);
        // Nine-bit ring formed by B1 and B8
        rotr_b8 = {b1, b8[DW-1:1]};
        rotr_b1 = b8[0];
        rotl_b8 = {b8[DW-2:0], b1};
        rotl_b1 = b8[DW-1];
    end

    for (genvar i = 0; i < DW; i++) begin : g_lane
        pe_lut u_lut (.fn(fn), .a(a8[i]), .b(b8[i]), .y(log8[i]));
    end

    pe_lut u_lut_bit (.fn(fn), .a(a1), .b(b1), .y(log1));

endmodule

// File: rtl/pe_lmem.sv
module pe_lmem #(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we8,
    input  logic [DW-1:0] wd8,
    input  logic          we1,
    input  logic          wd1,
    output logic [DW-1:0] rd8,
    output logic          rd1
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    cells8 [DEPTH];
    logic [DEPTH-1:0] cells1;

    always_ff @(posedge clk) begin
        if (we8) begin
            cells8[addr] <= wd8;
        end
        if (we1) begin
            cells1[addr] <= wd1;
        end
    end

    // Combinational read, so operand and string compare see the cell in the same cycle
    always_comb begin
        rd8 = cells8[addr];
        rd1 = cells1[addr];
    end
endmodule

// File: rtl/simd_pe.sv
module simd_pe #(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [4:0]    opcode,
    input  logic [2:0]    src_sel,
    input  logic [2:0]    dst_sel,
    input  logic [3:0]    logic_fn,
    input  logic [DW-1:0] bcast_data,
    input  logic          str_mode,
    output logic [DW-1:0] rpt_byte,
    output logic          rpt_bit,
    output logic          enabled
);
    import pe_pkg::*;

    localparam int PAD = DW - AW;

    typedef struct packed {
        logic [DW-1:0] a8;
        logic [DW-1:0] b8;
        logic [DW-1:0] c8;
        logic [DW-1:0] io8;
        logic [AW-1:0] ptr;
        logic          a1;
        logic          b1;
        logic          c1;
        logic          io1;
        logic          run;
        logic [DW-1:0] rpt8;
        logic          rpt1;
    } pe_state_t;

    pe_state_t st_d, st_q;
    pe_op_e    op;

    logic [DW-1:0] ram8_rd;
    logic          ram1_rd;
    logic          we8_d, we1_d;
    logic [DW-1:0] byte_src;
    logic          bit_src;
    logic          bw_en, fw_en;
    logic [DW-1:0] bw_val;
    logic          fw_val;
    logic [AW-1:0] mar_cur;

    logic [DW-1:0] alu_sum, alu_diff, alu_log8, alu_rr8, alu_rl8;
    logic          alu_carry, alu_borrow, alu_eq, alu_gt, alu_log1, alu_rr1, alu_rl1;

    assign op      = pe_op_e'(opcode);
    assign mar_cur = st_q.ptr;

    // Operand selection
    always_comb begin
        case (src_sel)
            SEL_A:   byte_src = st_q.a8;
            SEL_B:   byte_src = st_q.b8;
            SEL_C:   byte_src = st_q.c8;
            SEL_IO:  byte_src = st_q.io8;
            SEL_PTR: byte_src = {{PAD{1'b0}}, st_q.ptr};
            SEL_MEM: byte_src = ram8_rd;
            default: byte_src = '0;
        endcase
        case (src_sel)
            SEL_A:   bit_src = st_q.a1;
            SEL_B:   bit_src = st_q.b1;
            SEL_C:   bit_src = st_q.c1;
            SEL_IO:  bit_src = st_q.io1;
            SEL_PTR: bit_src = st_q.run;
            SEL_MEM: bit_src = ram1_rd;
            default: bit_src = 1'b0;
        endcase
    end

    pe_alu #(.DW(DW)) u_alu (
        .a8(st_q.a8), .b8(st_q.b8), .opnd(byte_src),
        .a1(st_q.a1), .b1(st_q.b1), .c1(st_q.c1), .fn(logic_fn),
        .sum(alu_sum), .carry(alu_carry), .diff(alu_diff), .borrow(alu_borrow),
        .eq(alu_eq), .gt(alu_gt), .log8(alu_log8), .log1(alu_log1),
        .rotr_b8(alu_rr8), .rotr_b1(alu_rr1), .rotl_b8(alu_rl8), .rotl_b1(alu_rl1)
    );

    pe_lmem #(.DW(DW), .AW(AW)) u_mem (
        .clk(clk), .addr(st_q.ptr),
        .we8(we8_d), .wd8(byte_src), .we1(we1_d), .wd1(bit_src),
        .rd8(ram8_rd), .rd1(ram1_rd)
    );

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        we8_d  = 1'b0;
        we1_d  = 1'b0;
        bw_en  = 1'b0;
        bw_val = byte_src;
        fw_en  = 1'b0;
        fw_val = bit_src;
        if (op_valid) begin
            if (str_mode) begin
                if (st_q.run) begin
                    st_d.ptr = st_q.ptr + 1'b1;
                    if (bcast_data != ram8_rd) begin
                        st_d.run = 1'b0;
                    end
                end
            end else if (op == OP_ENABLE) begin
                st_d.run = 1'b1;
            end else if (st_q.run) begin
                case (op)
                    OP_MOV8: bw_en = 1'b1;
                    OP_MOV1: fw_en = 1'b1;
                    OP_RD8: begin
                        bw_en  = 1'b1;
                        bw_val = ram8_rd;
                    end
                    OP_WR8:  we8_d = 1'b1;
                    OP_RD1: begin
                        fw_en  = 1'b1;
                        fw_val = ram1_rd;
                    end
                    OP_WR1:  we1_d = 1'b1;
                    OP_INC:  st_d.ptr = st_q.ptr + 1'b1;
                    OP_ADD: begin
                        st_d.c8 = alu_sum;
                        st_d.c1 = alu_carry;
                    end
                    OP_SUB: begin
                        st_d.c8 = alu_diff;
                        st_d.c1 = alu_borrow;
                    end
                    OP_CMP: begin
                        st_d.a1 = alu_eq;
                        st_d.b1 = alu_gt;
                    end
                    OP_ROTR: begin
                        st_d.b8 = alu_rr8;
                        st_d.b1 = alu_rr1;
                    end
                    OP_ROTL: begin
                        st_d.b8 = alu_rl8;
                        st_d.b1 = alu_rl1;
                    end
                    OP_LOG8: st_d.c8 = alu_log8;
                    OP_LOG1: st_d.c1 = alu_log1;
                    OP_BC8: begin
                        bw_en  = 1'b1;
                        bw_val = bcast_data;
                    end
                    OP_BC1: begin
                        fw_en  = 1'b1;
                        fw_val = bcast_data[0];
                    end
                    OP_REP8: st_d.rpt8 = byte_src;
                    OP_REP1: st_d.rpt1 = bit_src;
                    default: ;
                endcase
                if (bw_en) begin
                    case (dst_sel)
                        SEL_A:   st_d.a8  = bw_val;
                        SEL_B:   st_d.b8  = bw_val;
                        SEL_C:   st_d.c8  = bw_val;
                        SEL_IO:  st_d.io8 = bw_val;
                        SEL_PTR: st_d.ptr = bw_val[AW-1:0];
                        default: ;
                    endcase
                end
                if (fw_en) begin
                    case (dst_sel)
                        SEL_A:   st_d.a1  = fw_val;
                        SEL_B:   st_d.b1  = fw_val;
                        SEL_C:   st_d.c1  = fw_val;
                        SEL_IO:  st_d.io1 = fw_val;
                        SEL_PTR: st_d.run = fw_val;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.run <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rpt_byte = st_q.rpt8;
    assign rpt_bit  = st_q.rpt1;
    assign enabled  = st_q.run;

endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [4:0]    opcode,
    input logic          str_mode,
    input logic [DW-1:0] bcast_data,
    input logic [DW-1:0] rpt_byte,
    input logic          rpt_bit,
    input logic          enabled,
    input logic [AW-1:0] mar,
    input logic [DW-1:0] mem_byte
);
    import pe_pkg::*;

    logic is_enable, is_inc;
    assign is_enable = (opcode == OP_ENABLE);
    assign is_inc    = (opcode == OP_INC);

    assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !str_mode && is_enable |=> enabled);

    assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !str_mode && !enabled && !is_enable
        |=> !enabled && $stable(rpt_byte) && $stable(rpt_bit) && $stable(mar));

    assert_str_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && str_mode && enabled && (bcast_data != mem_byte) |=> !enabled);

    assert_str_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && str_mode && enabled |=> mar == AW'($past(mar) + 1'b1));

    assert_str_no_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && str_mode |=> !$rose(enabled));

    assert_inc_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !str_mode && enabled && is_inc |=> mar == AW'($past(mar) + 1'b1));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(mar) && $stable(enabled) && $stable(rpt_byte) && $stable(rpt_bit));

endmodule

bind simd_pe pe_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .str_mode(str_mode), .bcast_data(bcast_data), .rpt_byte(rpt_byte),
    .rpt_bit(rpt_bit), .enabled(enabled), .mar(mar_cur), .mem_byte(ram8_rd)
);

// File: tb/tb_simd_pe.sv
module tb_simd_pe;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] opcode = '0;
    logic [2:0] src_sel = '0;
    logic [2:0] dst_sel = '0;
    logic [3:0] logic_fn = '0;
    logic [7:0] bcast_data = '0;
    logic       str_mode = 1'b0;
    logic [7:0] rpt_byte;
    logic       rpt_bit;
    logic       enabled;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state: index 0..4 = A,B,C,IO,PTR (bytes) and A1,B1,C1,IO1,RUN (bits)
    int r8 [5];
    int r1 [5];
    int mem8 [64];
    int mem1 [64];
    int ref_rb = 0;
    int ref_rbit = 0;

    always #2.5 clk = ~clk;

    simd_pe dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .src_sel(src_sel), .dst_sel(dst_sel), .logic_fn(logic_fn),
        .bcast_data(bcast_data), .str_mode(str_mode),
        .rpt_byte(rpt_byte), .rpt_bit(rpt_bit), .enabled(enabled)
    );

    function automatic int get8(int s);
        if (s < 5) return r8[s];
        if (s == 5) return mem8[r8[4]];
        return 0;
    endfunction

    function automatic int get1(int s);
        if (s < 5) return r1[s];
        if (s == 5) return mem1[r8[4]];
        return 0;
    endfunction

    task automatic put8(int d, int v);
        if (d == 4) r8[4] = v % 64;
        else if (d < 4) r8[d] = v % 256;
    endtask

    task automatic put1(int d, int v);
        if (d < 5) r1[d] = v & 1;
    endtask

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One instruction: update the model, drive, clock, compare all outputs.
    task automatic step(int op, int s, int d, int fn, int data, bit sm, string req, bit vld = 1);
        int opnd, obit, t;
        opnd = get8(s);
        obit = get1(s);
        if (vld) begin
            if (sm) begin
                if (r1[4] == 1) begin
                    if (data != mem8[r8[4]]) r1[4] = 0;
                    r8[4] = (r8[4] + 1) % 64;
                end
            end else if (op == 17) begin
                r1[4] = 1;
            end else if (r1[4] == 1) begin
                case (op)
                    1: put8(d, opnd);
                    2: put1(d, obit);
                    3: put8(d, mem8[r8[4]]);
                    4: mem8[r8[4]] = opnd;
                    5: put1(d, mem1[r8[4]]);
                    6: mem1[r8[4]] = obit;
                    7: r8[4] = (r8[4] + 1) % 64;
                    8: begin t = opnd + r8[0] + r1[2]; r8[2] = t % 256; r1[2] = t / 256; end
                    9: begin t = r8[0] - opnd - r1[2]; r1[2] = (t < 0) ? 1 : 0; r8[2] = (t + 512) % 256; end
                    10: begin r1[0] = (opnd == r8[0]) ? 1 : 0; r1[1] = (opnd > r8[0]) ? 1 : 0; end
                    11: begin t = r8[1]; r8[1] = (t >> 1) | (r1[1] << 7); r1[1] = t & 1; end
                    12: begin t = r8[1]; r8[1] = ((t << 1) & 255) | r1[1]; r1[1] = t >> 7; end
                    13: begin
                        t = 0;
                        for (int i = 0; i < 8; i++)
                            t |= ((fn >> (2 * ((r8[0] >> i) & 1) + ((r8[1] >> i) & 1))) & 1) << i;
                        r8[2] = t;
                    end
                    14: r1[2] = (fn >> (2 * r1[0] + r1[1])) & 1;
                    15: put8(d, data & 255);
                    16: put1(d, data & 1);
                    18: ref_rb = opnd;
                    19: ref_rbit = obit;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        op_valid = vld; opcode = 5'(op); src_sel = 3'(s); dst_sel = 3'(d);
        logic_fn = 4'(fn); bcast_data = 8'(data); str_mode = sm;
        @(posedge clk);
        #1;
        check(req, int'(rpt_byte), ref_rb, "rpt_byte");
        check(req, int'(rpt_bit), ref_rbit, "rpt_bit");
        check(req, int'(enabled), r1[4], "enabled");
    endtask

    task automatic report8(int s, string req);
        step(18, s, 0, 0, 0, 0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++) begin r8[i] = 0; r1[i] = 0; end
        r1[4] = 1;
        for (int i = 0; i < 64; i++) begin mem8[i] = 0; mem1[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset values on the ports
        check("R1", int'(rpt_byte), 0, "rpt_byte after reset");
        check("R1", int'(rpt_bit), 0, "rpt_bit after reset");
        check("R1", int'(enabled), 1, "enabled after reset");
        for (int s = 0; s < 5; s++) report8(s, "R1");
        for (int s = 0; s < 5; s++) step(19, s, 0, 0, 0, 0, "R1");
        // Fill the store (R8) so every cell is known
        step(15, 0, 4, 0, 0, 0, "R8");
        for (int i = 0; i < 64; i++) begin
            step(15, 0, 0, 0, (i * 37 + 11) & 255, 0, "R8");
            step(4, 0, 0, 0, 0, 0, "R8");
            step(16, 0, 1, 0, i, 0, "R8");
            step(6, 1, 0, 0, 0, 0, "R8");
            step(7, 0, 0, 0, 0, 0, "R8");
        end
        report8(4, "R8");
        // R10: broadcasts, R11: moves
        step(15, 0, 0, 0, 8'h5A, 0, "R10"); report8(0, "R10");
        step(15, 0, 1, 0, 8'h3C, 0, "R10"); report8(1, "R10");
        step(15, 0, 4, 0, 8'hFE, 0, "R10"); report8(4, "R10");
        step(1, 0, 3, 0, 0, 0, "R11"); report8(3, "R11");
        step(16, 0, 3, 0, 1, 0, "R10"); step(2, 3, 0, 0, 0, 0, "R11"); step(19, 0, 0, 0, 0, 0, "R11");
        step(1, 0, 6, 0, 0, 0, "R11"); report8(6, "R11");
        // R8: read and wrap
        step(3, 0, 2, 0, 0, 0, "R8"); report8(2, "R8");
        step(7, 0, 0, 0, 0, 0, "R8"); step(7, 0, 0, 0, 0, 0, "R8"); report8(4, "R8");
        step(5, 0, 0, 0, 0, 0, "R8"); step(19, 0, 0, 0, 0, 0, "R8");
        // R2: add with carry chain
        step(15, 0, 0, 0, 8'hF0, 0, "R2"); step(15, 0, 1, 0, 8'h20, 0, "R2");
        step(16, 0, 2, 0, 0, 0, "R2");
        step(8, 1, 0, 0, 0, 0, "R2"); report8(2, "R2"); step(19, 2, 0, 0, 0, 0, "R2");
        step(8, 1, 0, 0, 0, 0, "R2"); report8(2, "R2"); step(19, 2, 0, 0, 0, 0, "R2");
        // R3: subtract with borrow
        step(16, 0, 2, 0, 0, 0, "R3"); step(15, 0, 0, 0, 8'h10, 0, "R3");
        step(9, 1, 0, 0, 0, 0, "R3"); report8(2, "R3"); step(19, 2, 0, 0, 0, 0, "R3");
        step(9, 1, 0, 0, 0, 0, "R3"); report8(2, "R3"); step(19, 2, 0, 0, 0, 0, "R3");
        // R4: compare equal, greater, less
        step(15, 0, 1, 0, 8'h10, 0, "R4"); step(10, 1, 0, 0, 0, 0, "R4");
        step(19, 0, 0, 0, 0, 0, "R4"); step(19, 1, 0, 0, 0, 0, "R4");
        step(15, 0, 1, 0, 8'h11, 0, "R4"); step(10, 1, 0, 0, 0, 0, "R4");
        step(19, 0, 0, 0, 0, 0, "R4"); step(19, 1, 0, 0, 0, 0, "R4");
        step(15, 0, 1, 0, 8'h0F, 0, "R4"); step(10, 1, 0, 0, 0, 0, "R4");
        step(19, 0, 0, 0, 0, 0, "R4"); step(19, 1, 0, 0, 0, 0, "R4");
        // R5: nine rotates return the ring to its start
        step(15, 0, 1, 0, 8'h81, 0, "R5"); step(16, 0, 1, 0, 0, 0, "R5");
        for (int k = 0; k < 9; k++) begin
            step(11, 0, 0, 0, 0, 0, "R5"); report8(1, "R5"); step(19, 1, 0, 0, 0, 0, "R5");
        end
        for (int k = 0; k < 9; k++) begin
            step(12, 0, 0, 0, 0, 0, "R5"); report8(1, "R5"); step(19, 1, 0, 0, 0, 0, "R5");
        end
        // R6: all sixteen truth tables on bytes and on every flag pair
        step(15, 0, 0, 0, 8'hCC, 0, "R6"); step(15, 0, 1, 0, 8'hAA, 0, "R6");
        for (int f = 0; f < 16; f++) begin
            step(13, 0, 0, f, 0, 0, "R6"); report8(2, "R6");
        end
        for (int p = 0; p < 4; p++) begin
            step(16, 0, 0, 0, p >> 1, 0, "R6"); step(16, 0, 1, 0, p & 1, 0, "R6");
            for (int f = 0; f < 16; f++) begin
                step(14, 0, 0, f, 0, 0, "R6"); step(19, 2, 0, 0, 0, 0, "R6");
            end
        end
        // R9: matching string keeps RUN and advances PTR
        step(15, 0, 4, 0, 10, 0, "R9");
        for (int i = 10; i < 14; i++) step(0, 0, 0, 0, mem8[i], 1, "R9");
        report8(4, "R9");
        // R9: mismatch on second byte, later matching bytes ignored
        step(15, 0, 4, 0, 20, 0, "R9");
        step(0, 0, 0, 0, mem8[20], 1, "R9");
        step(0, 0, 0, 0, mem8[21] ^ 1, 1, "R9");
        for (int i = 22; i < 26; i++) step(17, 0, 0, 0, mem8[i], 1, "R9");
        // R7: a sleeping element ignores all but ENABLE
        step(15, 0, 0, 0, 8'h77, 0, "R7"); step(18, 0, 0, 0, 0, 0, "R7");
        step(8, 1, 0, 0, 0, 0, "R7"); step(7, 0, 0, 0, 0, 0, "R7");
        step(17, 0, 0, 0, 0, 0, "R7");
        report8(4, "R9"); report8(0, "R7"); report8(2, "R7");
        step(16, 0, 4, 0, 0, 0, "R7"); step(15, 0, 1, 0, 8'h12, 0, "R7");
        step(0, 0, 0, 0, 0, 0, "R11", 0);
        step(17, 0, 0, 0, 0, 0, "R7"); step(17, 0, 0, 0, 0, 0, "R7"); report8(1, "R7");
        // Mixed stream against the model
        for (int n = 0; n < 3000; n++) begin
            int rop, rs, rd, rf, rdat;
            bit rsm;
            rop = $urandom_range(0, 31);
            rs = $urandom_range(0, 7);
            rd = $urandom_range(0, 7);
            rf = $urandom_range(0, 15);
            rdat = $urandom_range(0, 255);
            rsm = ($urandom_range(0, 9) == 0);
            if (rsm && $urandom_range(0, 1) == 1) rdat = mem8[r8[4]];
            step(rop, rs, rd, rf, rdat, rsm, "R11", ($urandom_range(0, 7) != 0));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule